// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

A 16-bit up-counter with a companion 16-bit holding register. When the mode bit selects reload, the holding register supplies the value the counter restarts from after each rollover. The counter then produces overflows at a fixed, programmable period. When the mode bit selects capture, the counter rolls over to zero. A falling edge on a trigger pin then copies the live count into the holding register, so the time of an external event can be measured.

The count advances on one of three sources. The first is every system clock. The second is one system clock in twelve. The third is the falling edges of an external count pin. Both external pins pass through a two-flop synchronizer before edge detection. Software sets up the block through three write ports: one for the control byte, one for the count and one for the holding register. The same state is read back on output ports. Two sticky flags, one for overflow and one for external events, feed a single interrupt request.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the count, the holding register and the control byte read 0, and the interrupt request is low.
- R2: While the run bit (control bit 2) is 0, the count does not change except through a software count write.
- R3: With the counter/timer select bit (control bit 1) at 0 and run at 1, the count advances every clock when `clk_sel` is 1. When `clk_sel` is 0 it advances every 12th clock, and the first step comes 12 clocks after run is written.
- R4: With control bit 1 at 1, the count advances once per falling edge of `cnt_pin`, three clocks after the edge. Rising edges do not advance it.
- R5: A step from FFFFh sets the overflow flag (control bit 7). In capture mode (control bit 0 at 1) the count then reads 0000h.
- R6: In reload mode (control bit 0 at 0), a step from FFFFh loads the holding register into the count. With the holding register at 10000h−N and the count at FFFFh, the count reads 10000h−N+((k−1) mod N) k ticks after run starts, for k ≥ 1.
- R7: In capture mode with run and the external enable bit (control bit 3) at 1, a falling edge on `trig_pin` copies the count into the holding register three clocks later. It also sets the external flag (control bit 6).
- R8: With external enable at 0, `trig_pin` edges change neither the holding register nor the external flag.
- R9: In reload mode with run and external enable at 1, a falling edge on `trig_pin` loads the holding register into the count and sets the external flag.
- R10: Both flags stay set until a control write places 0 in their bit. A hardware set in the same cycle as a clearing write wins.
- R11: `irq_o` is high exactly when `irq_en` is 1 and at least one flag is set.
- R12: If a capture and a count step fall in the same clock, the value captured is the count before the step.
- R13: A software count write takes effect in place of a step in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 1 | 1: step every clock; 0: every 12th clock |
| irq_en | input | 1 | Interrupt enable |
| cnt_pin | input | 1 | External count source (falling edges) |
| trig_pin | input | 1 | External capture/reload trigger (falling edges) |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write value |
| hold_we | input | 1 | Holding register write strobe |
| hold_wdata | input | 16 | Holding register write value |
| count_o | output | 16 | Current count |
| hold_o | output | 16 | Holding register |
| ctrl_o | output | 8 | Control byte readback, unused bits 0 |
| ovf_o | output | 1 | Overflow flag |
| exf_o | output | 1 | External event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A trigger capture and a count step can land on the same clock, and so can a flag set and a software clear of that flag. The bench runs the counter on every clock and sweeps the gap before each trigger edge, so every capture coincides with a step. It expects the count read two clocks after the trigger fell, which is the value before the third step. For the flags, it holds the period at one tick so that an overflow occurs on every clock, issues clearing control writes, and requires the flag to stay set until a write lands on a clock with no step.

// File: rtl/ctm_pkg.sv
// Shared constants for the capture/reload timer: control byte bit
// positions. Assumes an 8-bit control byte with unused bits reading 0.
package ctm_pkg;
    localparam int CTRL_W     = 8;
    localparam int B_CAPMODE  = 0;
    localparam int B_EXTCNT   = 1;
    localparam int B_RUN      = 2;
    localparam int B_EXTEN    = 3;
    localparam int B_EXF      = 6;
    localparam int B_OVF      = 7;
endpackage

// File: rtl/ctm_edge_fall.sv
// Synchronizes an asynchronous pin through STAGES flops and reports a
// one-clock pulse on each high-to-low transition. Assumes the pin idles
// high, so all flops reset to 1 and no edge appears out of reset.
module ctm_edge_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_sync
            // Shift the pin level one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[gi] <= 1'b1;
                else if (gi == 0) sync_q[gi] <= pin;
                else sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ctm_tick_gen.sv
// Chooses the count step source: every clock, one clock in PRESCALE, or
// a synchronized falling edge of the count pin. The prescaler is held at
// zero while not in use, so the first divided step is PRESCALE clocks
// after run rises.
module ctm_tick_gen #(
    parameter int PRESCALE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_cnt,
    input  logic clk_sel,
    input  logic pin_fall,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;
    logic          active;
    logic          div_tick;

    assign active   = run & ~ext_cnt;
    assign div_tick = active & (pre_q == LAST);

    // Divide the clock by PRESCALE while internally clocked and running.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
    end

    // Select the step source from the mode inputs.
    always_comb begin
        if (!run)         tick = 1'b0;
        else if (ext_cnt) tick = pin_fall;
        else if (clk_sel) tick = 1'b1;
        else              tick = div_tick;
    end
endmodule

// File: rtl/ctm_count_core.sv
// Counter and holding register. Applies, in priority order, software count
// writes, trigger reloads and steps. In capture mode a trigger copies the
// pre-step count into the holding register. Reports rollover and
// external events as single-cycle set pulses.
module ctm_count_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cap_mode,
    input  logic          ext_evt,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          hold_we,
    input  logic [CW-1:0] hold_wdata,
    output logic [CW-1:0] count,
    output logic [CW-1:0] hold,
    output logic          ovf_set,
    output logic          exf_set
);
    logic [CW-1:0] count_d;
    logic [CW-1:0] hold_d;
    logic          wrap;

    assign wrap    = tick & (count == {CW{1'b1}});
    assign ovf_set = wrap;
    assign exf_set = ext_evt;

    // Next count: software write, then trigger reload, then step.
    always_comb begin
        count_d = count;
        if (cnt_we)                   count_d = cnt_wdata;
        else if (ext_evt && !cap_mode) count_d = hold;
        else if (wrap)                count_d = cap_mode ? '0 : hold;
        else if (tick)                count_d = count + 1'b1;
    end

    // Next holding value: capture wins over a software write.
    always_comb begin
        hold_d = hold;
        if (ext_evt && cap_mode) hold_d = count;
        else if (hold_we)        hold_d = hold_wdata;
    end

    // Register count and holding value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            hold  <= '0;
        end else begin
            count <= count_d;
            hold  <= hold_d;
        end
    end
endmodule

// File: rtl/cap_reload_timer.sv
// Top of the capture/reload timer. Holds the control byte and sticky flags
// (hardware set beats a same-cycle software clear) and wires the edge
// detectors, step source and counter core. Assumes pins idle high.
module cap_reload_timer #(
    parameter int CW          = 16,
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_sel,
    input  logic          irq_en,
    input  logic          cnt_pin,
    input  logic          trig_pin,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          hold_we,
    input  logic [CW-1:0] hold_wdata,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] hold_o,
    output logic [7:0]    ctrl_o,
    output logic          ovf_o,
    output logic          exf_o,
    output logic          irq_o
);
    import ctm_pkg::*;

    logic cap_mode_q, ext_cnt_q, run_q, ext_en_q, exf_q, ovf_q;
    logic cnt_fall, trig_fall, tick, ext_evt, ovf_set, exf_set;

    ctm_edge_fall #(.STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));

    ctm_edge_fall #(.STAGES(SYNC_STAGES)) u_trig_edge (
        .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

    ctm_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run_q), .ext_cnt(ext_cnt_q),
        .clk_sel(clk_sel), .pin_fall(cnt_fall), .tick(tick));

    assign ext_evt = trig_fall & run_q & ext_en_q;

    ctm_count_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_mode(cap_mode_q),
        .ext_evt(ext_evt), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .hold_we(hold_we), .hold_wdata(hold_wdata), .count(count_o),
        .hold(hold_o), .ovf_set(ovf_set), .exf_set(exf_set));

    // Control fields load on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_mode_q <= 1'b0;
            ext_cnt_q  <= 1'b0;
            run_q      <= 1'b0;
            ext_en_q   <= 1'b0;
        end else if (ctrl_we) begin
            cap_mode_q <= ctrl_wdata[B_CAPMODE];
            ext_cnt_q  <= ctrl_wdata[B_EXTCNT];
            run_q      <= ctrl_wdata[B_RUN];
            ext_en_q   <= ctrl_wdata[B_EXTEN];
        end
    end

    // Sticky flags: software write value, overridden by a hardware set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            exf_q <= 1'b0;
        end else begin
            ovf_q <= (ctrl_we ? ctrl_wdata[B_OVF] : ovf_q) | ovf_set;
            exf_q <= (ctrl_we ? ctrl_wdata[B_EXF] : exf_q) | exf_set;
        end
    end

    assign ctrl_o = {ovf_q, exf_q, 2'b00, ext_en_q, run_q, ext_cnt_q, cap_mode_q};
    assign ovf_o  = ovf_q;
    assign exf_o  = exf_q;
    assign irq_o  = irq_en & (ovf_q | exf_q);
endmodule

// File: rtl/ctm_checker.sv
// Temporal checks on the timer's ports, bound to every instance of the top.
module ctm_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_we,
    input logic          cnt_we,
    input logic          hold_we,
    input logic          irq_en,
    input logic [CW-1:0] count_o,
    input logic [CW-1:0] hold_o,
    input logic [7:0]    ctrl_o,
    input logic          ovf_o,
    input logic          exf_o,
    input logic          irq_o
);
    logic seen_q;

    // Marks that at least one clock has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);

    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf_o || exf_o));

    p_ovf_from_rollover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(ovf_o) && !$past(ctrl_we)) |-> ($past(count_o) == {CW{1'b1}}));

    p_flag_clear_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($fell(ovf_o) || $fell(exf_o))) |-> $past(ctrl_we));

    p_off_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(ctrl_o[2]) && !$past(cnt_we)) |-> $stable(count_o));

    p_hold_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(hold_we) && (hold_o != $past(hold_o))) |-> exf_o);

    p_ext_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(exf_o) && !$past(ctrl_we)) |-> $past(ctrl_o[3]));
endmodule

bind cap_reload_timer ctm_checker #(.CW(CW)) u_ctm_checker (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .cnt_we(cnt_we),
    .hold_we(hold_we), .irq_en(irq_en), .count_o(count_o), .hold_o(hold_o),
    .ctrl_o(ctrl_o), .ovf_o(ovf_o), .exf_o(exf_o), .irq_o(irq_o));

// File: tb/test_cap_reload_timer.sv
module test_cap_reload_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_sel = 1'b1, irq_en = 1'b0;
    logic        cnt_pin = 1'b1, trig_pin = 1'b1;
    logic        ctrl_we = 1'b0, cnt_we = 1'b0, hold_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [15:0] cnt_wdata = '0, hold_wdata = '0;
    logic [15:0] count_o, hold_o;
    logic [7:0]  ctrl_o;
    logic        ovf_o, exf_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_reload_timer i_cap_reload_timer (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .irq_en(irq_en),
        .cnt_pin(cnt_pin), .trig_pin(trig_pin), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .hold_we(hold_we), .hold_wdata(hold_wdata), .count_o(count_o),
        .hold_o(hold_o), .ctrl_o(ctrl_o), .ovf_o(ovf_o), .exf_o(exf_o),
        .irq_o(irq_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wr_hold(input logic [15:0] v);
        @(negedge clk); hold_we = 1'b1; hold_wdata = v;
        @(negedge clk); hold_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] c, h;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        check("R1 count", count_o, 0);
        check("R1 hold", hold_o, 0);
        check("R1 ctrl", ctrl_o, 0);
        check("R1 irq", irq_o, 0);

        // R2 stopped timer keeps its count
        wr_cnt(16'h0042);
        wait_n(10);
        check("R2 count while off", count_o, 16'h0042);

        // R3 every-clock stepping, R13 write beats step
        wr_ctrl(8'h04);
        check("R3 count at run edge", count_o, 16'h0042);
        wait_n(1);
        check("R3 one step per clock", count_o, 16'h0043);
        wr_cnt(16'h5000);
        check("R13 write replaces step", count_o, 16'h5000);
        wait_n(1);
        check("R13 step after write", count_o, 16'h5001);

        // R3 divide-by-12 stepping
        wr_ctrl(8'h00);
        clk_sel = 1'b0;
        wr_cnt(16'h0010);
        wr_ctrl(8'h04);
        wait_n(11);
        check("R3 no step before 12 clocks", count_o, 16'h0010);
        wait_n(1);
        check("R3 step at 12 clocks", count_o, 16'h0011);
        wait_n(12);
        check("R3 step at 24 clocks", count_o, 16'h0012);

        // R5 capture-mode rollover to zero with overflow flag
        wr_ctrl(8'h00);
        clk_sel = 1'b1;
        wr_cnt(16'hFFFE);
        wr_ctrl(8'h05);
        wait_n(1);
        check("R5 count before wrap", count_o, 16'hFFFF);
        check("R5 no flag before wrap", ovf_o, 0);
        wait_n(1);
        check("R5 wrap to zero", count_o, 16'h0000);
        check("R5 overflow flag", ctrl_o[7], 1);

        // R6 reload period sweep, N = 1..16
        for (int n = 1; n <= 16; n++) begin
            wr_ctrl(8'h00);
            wr_hold(16'(17'h10000 - n));
            wr_cnt(16'hFFFF);
            wr_ctrl(8'h04);
            for (int k = 1; k <= 3 * n; k++) begin
                wait_n(1);
                check($sformatf("R6 period %0d tick %0d", n, k), count_o,
                      32'(16'(17'h10000 - n + ((k - 1) % n))));
            end
            check($sformatf("R6 overflow flag period %0d", n), ovf_o, 1);
        end

        // R4 external count pin
        wr_ctrl(8'h00);
        wr_cnt(16'h0100);
        wr_ctrl(8'h06);
        cnt_pin = 1'b0;
        wait_n(2);
        check("R4 no step before sync delay", count_o, 16'h0100);
        wait_n(1);
        check("R4 step three clocks after fall", count_o, 16'h0101);
        cnt_pin = 1'b1;
        wait_n(5);
        check("R4 rising edge ignored", count_o, 16'h0101);
        for (int p = 1; p <= 6; p++) begin
            cnt_pin = 1'b0; wait_n(3 + p);
            cnt_pin = 1'b1; wait_n(4);
            check("R4 pulse count", count_o, 32'(16'h0101 + p));
        end

        // R7 / R12 capture sweep; each capture coincides with a step
        wr_ctrl(8'h00);
        wr_cnt(16'h0000);
        wr_ctrl(8'h0D);
        for (int i = 0; i < 8; i++) begin
            wait_n(i * 3 + 1);
            c = count_o;
            trig_pin = 1'b0;
            wait_n(3);
            check("R12 captured pre-step count", hold_o, 32'(16'(c + 2)));
            check("R7 external flag", ctrl_o[6], 1);
            trig_pin = 1'b1;
            wait_n(4);
        end
        irq_en = 1'b0;
        wait_n(1);
        check("R11 irq masked", irq_o, 0);
        irq_en = 1'b1;
        wait_n(1);
        check("R11 irq from external flag", irq_o, 1);
        wait_n(20);
        check("R10 flag stays set", exf_o, 1);
        wr_ctrl(8'h0D);
        check("R10 flag cleared by write", exf_o, 0);
        check("R11 irq drops with flags", irq_o, 0);

        // R8 trigger ignored with external enable off
        wr_ctrl(8'h05);
        h = hold_o;
        trig_pin = 1'b0;
        wait_n(4);
        check("R8 hold unchanged", hold_o, 32'(h));
        check("R8 flag unchanged", exf_o, 0);
        trig_pin = 1'b1;
        wait_n(4);

        // R9 trigger-forced reload
        wr_ctrl(8'h00);
        wr_hold(16'h1234);
        wr_cnt(16'h0000);
        wr_ctrl(8'h0C);
        wait_n(2);
        trig_pin = 1'b0;
        wait_n(3);
        check("R9 forced reload", count_o, 16'h1234);
        check("R9 external flag", exf_o, 1);
        wait_n(1);
        check("R9 counting resumes", count_o, 16'h1235);
        trig_pin = 1'b1;
        wait_n(4);

        // R10 hardware set wins over same-cycle clear
        wr_ctrl(8'h00);
        wr_hold(16'hFFFF);
        wr_cnt(16'hFFFF);
        wr_ctrl(8'h04);
        wait_n(2);
        check("R10 overflow every tick", ovf_o, 1);
        wr_ctrl(8'h04);
        check("R10 set beats clear", ovf_o, 1);
        wr_ctrl(8'h00);
        check("R10 last step beats clear", ovf_o, 1);
        wr_ctrl(8'h00);
        check("R10 clear when idle", ovf_o, 0);

        finish_run();
    end
endmodule